// File: doc/BRIEF.md
# Two-Stage Cascaded Boxcar Averager

This block is a programmable low-pass filter for a stream of signed 14-bit samples. Two identical moving-average stages run back to back. Each averages the last N = 2^m samples it has accepted, and together they give a triangular (Bartlett) FIR response. Each stage keeps a running sum and a circular history buffer. On every accepted sample it adds the new value and removes the value that falls out of the window, then divides by N with an arithmetic right shift.

A 3-bit tap setting chooses m, and a 3-bit range code can force a larger minimum window. Narrower measurement ranges need more averaging to keep resolution. Any change to either setting clears both stages, so a new window never mixes histories from two lengths. A result leaves with its own valid strobe a fixed two cycles after the sample that produced it.

Top module: `tri_avg_filter`

## Requirements
- R1: While reset (`rstN` low) is held, `outValid` is 0 and `outSample` is 0.
- R2: `outValid` is high in cycle c+2 exactly when `inValid` was high in cycle c, with no exceptions.
- R3: Each stage's result is floor(S / N). S is the sum of the last N samples that the stage accepted since the most recent clear, with missing history counted as zero. The second stage averages the first stage's results, and `outSample` is the second stage's result.
- R4: With an effective m of 0 (N = 1), `outSample` in cycle c+2 equals the `inSample` accepted in cycle c.
- R5: Range code 3'b010 raises an effective m below 2 to 2. Range code 3'b001 raises an effective m below 4 to 4. Every other code, 3'b100 included, sets no floor.
- R6: A tap setting above 6 acts as 6, which is 64 taps per stage.
- R7: A cycle in which `tapLog` or `rangeSel` differs from its value in the previous cycle clears both histories and both sums. A sample entering a stage on that edge becomes the first entry of the new history. After reset, the previous values are taken as 0 and 3'b100.
- R8: A sample presented with `inValid` low has no effect on any later result. `outSample` holds its value in cycles where `outValid` is low.
- R9: Full-scale constant inputs (-8192 and +8191) settle to exactly that value at 64 taps, with no wrap of the sum or the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Sample strobe |
| inSample | input | 14 | Signed input sample |
| tapLog | input | 3 | Requested log2 of taps per stage |
| rangeSel | input | 3 | Measurement range code |
| outValid | output | 1 | Result strobe |
| outSample | output | 14 | Signed filtered result |

## Verification
The hardest state to reach is a settings change that lands while results are still in flight. In that case the second stage clears its history and then accepts a first-stage result that was computed under the old window. The sample that falls out of a full 64-entry ring is another hard case, because it is read from the same slot that is about to be written. The stimulus reaches both with long runs at 64 taps, random gaps in the strobe, and random settings changes that often land one or two cycles after an accepted sample. A cycle-level reference built from the stated rules predicts every result.

// File: rtl/tri_avg_pkg.sv
package tri_avg_pkg;
  localparam int SHIFT_W = 3;
  localparam logic [2:0] RANGE_WIDE   = 3'b100;
  localparam logic [2:0] RANGE_MID    = 3'b010;
  localparam logic [2:0] RANGE_NARROW = 3'b001;

  // strobes and settings handed from control to datapath each cycle
  typedef struct packed {
    logic               flush;
    logic [SHIFT_W-1:0] shift;
  } avg_cfg_t;
endpackage

// File: rtl/tri_avg_ctrl.sv
module tri_avg_ctrl
  import tri_avg_pkg::*;
#(
  parameter int LOG_MAX        = 6,
  parameter int MID_MIN_LOG    = 2,
  parameter int NARROW_MIN_LOG = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SHIFT_W-1:0] tapLog,
  input  logic [2:0]         rangeSel,
  output avg_cfg_t           cfg
);
  localparam logic [SHIFT_W-1:0] CAP_LOG   = SHIFT_W'(LOG_MAX);
  localparam logic [SHIFT_W-1:0] MID_LOG   = SHIFT_W'(MID_MIN_LOG);
  localparam logic [SHIFT_W-1:0] NARROW_LOG = SHIFT_W'(NARROW_MIN_LOG);

  logic [SHIFT_W-1:0] tapReg;
  logic [2:0]         rangeReg;
  logic [SHIFT_W-1:0] cappedLog;
  logic [SHIFT_W-1:0] floorLog;

  always_comb begin
    cappedLog = (tapLog > CAP_LOG) ? CAP_LOG : tapLog;
    case (rangeSel)
      RANGE_MID:    floorLog = MID_LOG;
      RANGE_NARROW: floorLog = NARROW_LOG;
      default:      floorLog = '0;
    endcase
    cfg.shift = (cappedLog < floorLog) ? floorLog : cappedLog;
    cfg.flush = (tapLog != tapReg) || (rangeSel != rangeReg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tapReg   <= '0;
      rangeReg <= RANGE_WIDE;
    end else begin
      tapReg   <= tapLog;
      rangeReg <= rangeSel;
    end
  end

  assert_mid_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rangeSel == RANGE_MID) |-> (cfg.shift >= MID_LOG));
  assert_narrow_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rangeSel == RANGE_NARROW) |-> (cfg.shift >= NARROW_LOG));
  assert_cap_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfg.shift <= CAP_LOG);
  // R7: a held setting never raises a clear on the next cycle
  assert_no_spurious_flush_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(tapLog) && $stable(rangeSel) && $past(rstN)) |-> !cfg.flush);
endmodule

// File: rtl/tri_avg_stage.sv
module tri_avg_stage
  import tri_avg_pkg::*;
#(
  parameter int DATA_W  = 14,
  parameter int LOG_MAX = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  avg_cfg_t                 cfg,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outData
);
  localparam int DEPTH = 1 << LOG_MAX;
  localparam int PTR_W = LOG_MAX;
  localparam int SUM_W = DATA_W + LOG_MAX + 1;

  logic signed [DATA_W-1:0] hist [DEPTH];
  logic [PTR_W-1:0]         wrPtr;
  logic signed [SUM_W-1:0]  sumQ;

  logic [PTR_W-1:0]         basePtr;
  logic [PTR_W-1:0]         rdIdx;
  logic signed [DATA_W-1:0] oldest;
  logic signed [SUM_W-1:0]  nextSum;
  logic signed [SUM_W-1:0]  avg;

  always_comb begin
    basePtr = cfg.flush ? '0 : wrPtr;
    // taps modulo DEPTH: a full ring reads the slot about to be overwritten
    rdIdx   = basePtr - PTR_W'((PTR_W+1)'(1) << cfg.shift);
    oldest  = cfg.flush ? '0 : hist[rdIdx];
    nextSum = (cfg.flush ? '0 : sumQ) + SUM_W'(inData) - SUM_W'(oldest);
    avg     = nextSum >>> cfg.shift;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      sumQ     <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else begin
      outValid <= inValid;
      if (cfg.flush) begin
        for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
        wrPtr <= '0;
        sumQ  <= '0;
      end
      if (inValid) begin
        hist[basePtr] <= inData;
        wrPtr         <= basePtr + 1'b1;
        sumQ          <= nextSum;
        outData       <= avg[DATA_W-1:0];
      end
    end
  end

  assert_passthrough_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cfg.shift == '0) |=> (outData == $past(inData)));
  assert_flush_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.flush && !inValid) |=> (sumQ == '0));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outData));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ((&avg[SUM_W-1:DATA_W-1]) || !(|avg[SUM_W-1:DATA_W-1])));
endmodule

// File: rtl/tri_avg_datapath.sv
module tri_avg_datapath
  import tri_avg_pkg::*;
#(
  parameter int DATA_W  = 14,
  parameter int LOG_MAX = 6,
  parameter int STAGES  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  avg_cfg_t                 cfg,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inSample,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outSample
);
  logic                     chainValid [STAGES+1];
  logic signed [DATA_W-1:0] chainData  [STAGES+1];

  assign chainValid[0] = inValid;
  assign chainData[0]  = inSample;

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    tri_avg_stage #(.DATA_W(DATA_W), .LOG_MAX(LOG_MAX)) uStage (
      .clk     (clk),
      .rstN    (rstN),
      .cfg     (cfg),
      .inValid (chainValid[g]),
      .inData  (chainData[g]),
      .outValid(chainValid[g+1]),
      .outData (chainData[g+1])
    );
  end

  assign outValid  = chainValid[STAGES];
  assign outSample = chainData[STAGES];

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##(STAGES-1) outValid);
  assert_no_extra_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ##(STAGES-1) !outValid);
endmodule

// File: rtl/tri_avg_filter.sv
module tri_avg_filter
  import tri_avg_pkg::*;
#(
  parameter int DATA_W  = 14,
  parameter int LOG_MAX = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inSample,
  input  logic [SHIFT_W-1:0]       tapLog,
  input  logic [2:0]               rangeSel,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outSample
);
  avg_cfg_t cfg;

  tri_avg_ctrl #(.LOG_MAX(LOG_MAX)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .tapLog  (tapLog),
    .rangeSel(rangeSel),
    .cfg     (cfg)
  );

  tri_avg_datapath #(.DATA_W(DATA_W), .LOG_MAX(LOG_MAX), .STAGES(2)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfg),
    .inValid  (inValid),
    .inSample (inSample),
    .outValid (outValid),
    .outSample(outSample)
  );
endmodule

// File: tb/tri_avg_filter_bench.sv
module tri_avg_filter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [13:0] inSample = '0;
  logic [2:0]  tapLog = '0;
  logic [2:0]  rangeSel = 3'b100;
  logic        outValid;
  logic [13:0] outSample;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tri_avg_filter u_tri_avg_filter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .tapLog(tapLog), .rangeSel(rangeSel),
    .outValid(outValid), .outSample(outSample)
  );

  // reference state built from the requirements
  int mHist [2][64];
  int mPtr [2];
  int mSum [2];
  int mOut [2];
  bit mValid [2];
  int prevM = 0;
  int prevR = 4;

  function automatic int effLog(int m, int r);
    int c = (m > 6) ? 6 : m;        // R6
    int f = (r == 2) ? 2 : ((r == 1) ? 4 : 0);  // R5
    return (c < f) ? f : c;
  endfunction

  task automatic stageModel(int k, bit v, int d, bit fl, int e);
    if (fl) begin                    // R7
      for (int i = 0; i < 64; i++) mHist[k][i] = 0;
      mPtr[k] = 0;
      mSum[k] = 0;
    end
    if (v) begin                     // R3
      int old = mHist[k][(mPtr[k] - (1 << e)) & 63];
      mSum[k] = mSum[k] + d - old;
      mHist[k][mPtr[k]] = d;
      mPtr[k] = (mPtr[k] + 1) & 63;
      mOut[k] = mSum[k] >>> e;
    end
    mValid[k] = v;
  endtask

  task automatic modelEdge(bit v, int s, int m, int r);
    bit fl = (m != prevM) || (r != prevR);
    int e = effLog(m, r);
    bit v2 = mValid[0];
    int d2 = mOut[0];
    prevM = m;
    prevR = r;
    stageModel(1, v2, d2, fl, e);
    stageModel(0, v, s, fl, e);
  endtask

  task automatic fail(string req, int act, int exp);
    errors++;
    $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  task automatic checkOut(string tag);
    checks++;
    if (outValid !== mValid[1]) fail("R2", int'(outValid), int'(mValid[1]));
    checks++;
    if (int'($signed(outSample)) != mOut[1]) fail(tag, int'($signed(outSample)), mOut[1]);
  endtask

  task automatic step(bit v, int s, int m, int r, string tag);
    @(negedge clk);
    checkOut(tag);
    inValid  = v;
    inSample = s[13:0];
    tapLog   = m[2:0];
    rangeSel = r[2:0];
    modelEdge(v, s, m, r);
  endtask

  function automatic int rndSample();
    return int'($urandom_range(16383)) - 8192;
  endfunction

  task automatic runRandom(int n, int m, int r, int pct, string tag);
    for (int i = 0; i < n; i++) begin
      bit v = ($urandom_range(99) < pct);
      step(v, rndSample(), m, r, tag);   // R8: garbage when v is low
    end
  endtask

  initial begin
    void'($urandom(32'h5A17));
    for (int k = 0; k < 2; k++) begin
      mPtr[k] = 0; mSum[k] = 0; mOut[k] = 0; mValid[k] = 1'b0;
      for (int i = 0; i < 64; i++) mHist[k][i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) fail("R1", int'(outValid), 0);
    checks++;
    if (outSample !== 14'd0) fail("R1", int'(outSample), 0);
    rstN = 1'b1;

    // R4: single tap passes samples straight through
    runRandom(24, 0, 4, 100, "R4");
    // R3 and R8: four taps with gaps in the strobe
    runRandom(60, 2, 4, 65, "R3");
    runRandom(40, 3, 4, 40, "R8");
    // R5: floors from the range code
    runRandom(40, 0, 2, 80, "R5");
    runRandom(80, 1, 1, 80, "R5");
    runRandom(30, 1, 7, 80, "R5");
    // R6: oversized setting behaves as 64 taps
    runRandom(200, 7, 4, 90, "R6");
    // R9: full-scale plateaus
    for (int i = 0; i < 140; i++) step(1'b1, 8191, 6, 4, "R9");
    step(1'b0, 0, 6, 4, "R9");
    step(1'b0, 0, 6, 4, "R9");
    checks++;
    if (int'($signed(outSample)) != 8191) fail("R9", int'($signed(outSample)), 8191);
    for (int i = 0; i < 140; i++) step(1'b1, -8192, 6, 4, "R9");
    step(1'b0, 0, 6, 4, "R9");
    step(1'b0, 0, 6, 4, "R9");
    checks++;
    if (int'($signed(outSample)) != -8192) fail("R9", int'($signed(outSample)), -8192);
    // R7: settings changes landing right after accepted samples
    for (int i = 0; i < 60; i++) begin
      int m = int'($urandom_range(7));
      int r = int'($urandom_range(7));
      step(1'b1, rndSample(), m, r, "R7");
      runRandom(int'($urandom_range(6)), m, r, 70, "R7");
    end
    // mixed random run
    begin
      int m = 2;
      int r = 4;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(99) < 2) begin
          m = int'($urandom_range(7));
          r = int'($urandom_range(1)) ? 4 : int'($urandom_range(2));
        end
        step($urandom_range(99) < 75, rndSample(), m, r, "R3");
      end
    end
    step(1'b0, 0, 0, 4, "R7");
    step(1'b0, 0, 0, 4, "R8");
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule